// File: doc/BRIEF.md
# UART-timed 1-Wire bus master

This block acts as the master of a single-wire, open-drain device bus. It makes each bus slot by sending one asynchronous serial character, ten bits long, onto the wire. The transmitter can only pull the wire low or let it go. The bit rate and the character's bit pattern are chosen so that the low part of the character has the duration the slot needs. A receiver watches the same wire. It samples the character that comes back, which includes whatever the addressed device added by pulling the wire low itself. From that echo the block decides the outcome of the slot.

A request names one of four slot kinds: bus reset with presence detect, write-0, write-1 or read. The block then loads the bit divisor for that slot kind and the pattern byte. It runs the frame and waits for both the transmit and the receive side to finish. Last it emits a one-cycle result with the slot's bit and a bus-short flag. The two divisors come from the clock frequency and two nominal bit rates, computed when the block is built. The pattern bytes come from the wanted low times measured in the actual bit period, so a clock that does not divide evenly still gives correct low times.

Command back-pressure: `cmd_ready` is high only while no slot is running. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_valid` while `cmd_ready` is low is ignored, and nothing is queued. The result side has no back-pressure: `res_valid` is a single-cycle pulse, and the result fields are held until the next result.

Top module: `owm_uart_master`

## Requirements
- R1: `cmd_ready` is high out of reset and whenever idle. It goes low in the cycle after a command is accepted and is high again in the cycle `res_valid` pulses. A `cmd_valid` seen while `cmd_ready` is low starts no slot and yields no result.
- R2: Command code 0 is a bus reset. It runs at divisor DR = round(CLK_HZ/RST_BAUD), and `ow_pull` is held for one unbroken stretch of LR·DR cycles. LR is defined in R5 and is 5 at the default rates, giving pattern 0xF0.
- R3: Command code 1 is write-0. It runs at divisor DS = round(CLK_HZ/SLOT_BAUD) and holds `ow_pull` for L0·DS cycles. L0 is 8 at the default rates, giving pattern 0x80.
- R4: Command code 2 (write-1) and command code 3 (read) both run at DS and hold `ow_pull` for L1·DS cycles. L1 is 1 at the default rates (start bit only), giving pattern 0xFF.
- R5: Each low-bit count L (start bit included) is round(low_ns·CLK_HZ / (div·1e9)), clamped to 1..9. The pattern byte is 0xFF shifted left by L−1. Characters go out least significant bit first, after a low start bit and before a high stop bit, and each bit lasts exactly div cycles.
- R6: For a reset, `res_bit` is 1 (device present) exactly when the echoed data byte differs from the reset pattern.
- R7: For a read, `res_bit` is 1 exactly when the echoed data byte is 0xFF. Any low data bit gives 0.
- R8: For either write, `res_bit` is 1 exactly when the echoed data byte equals the pattern that was sent.
- R9: `res_short` is 1 exactly when the echoed stop bit is sampled low.
- R10: `ow_pull` is never asserted while idle, and `res_valid` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | High when a command can be accepted (idle) |
| cmd_code | input | 2 | 0 reset, 1 write-0, 2 write-1, 3 read |
| res_valid | output | 1 | One-cycle pulse when a slot has finished |
| res_bit | output | 1 | Presence (reset), read bit (read) or echo match (write) |
| res_short | output | 1 | Stop bit of the echo was low |
| ow_pull | output | 1 | 1 pulls the bus wire low, 0 releases it |
| ow_sense | input | 1 | Bus wire level as seen by the receiver |

## Verification
The hardest outcomes to reach are those that depend on the device's own pull falling on the sampled bit centres of the echo. Such a pull must land after the master's low stretch and span certain sample instants. One case is presence after a reset. Another is a device pull that runs over the stop bit and so shows up as a short. The bench models the device as a low window timed from the first cycle of each slot's pull. It sweeps every command code against three device behaviours: silent, an early 30-cycle pull, and a late presence-style pull one reset bit long. Each combination is run with and without a wire held low. Expected echo bytes come from the bit-centre times, worked out arithmetically from the divisors and low-bit counts.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OWM_RESET = 2'd0,
    OWM_WR0   = 2'd1,
    OWM_WR1   = 2'd2,
    OWM_READ  = 2'd3
  } owm_cmd_e;

  // clock cycles per bit, rounded to nearest
  function automatic int owm_div(longint clk_hz, longint baud);
    return int'((clk_hz + baud / 2) / baud);
  endfunction

  // low bits (start included) that best fit a wanted low time
  function automatic int owm_low_bits(longint low_ns, longint clk_hz, longint div);
    longint den;
    longint n;
    den = div * 64'sd1000000000;
    n = (low_ns * clk_hz + den / 2) / den;
    if (n < 1) n = 1;
    if (n > 9) n = 9;
    return int'(n);
  endfunction

  // data byte whose leading L-1 bits are zero
  function automatic logic [7:0] owm_pattern(int n);
    return 8'hFF << (n - 1);
  endfunction

endpackage

// File: rtl/owm_bit_timer.sv
module owm_bit_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] load,
  input  logic [W-1:0] period,
  input  logic         run,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= load;
    end else if (tick) begin
      cnt <= period - W'(1);
    end else if (run) begin
      cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/owm_tx.sv
module owm_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [7:0]       pattern,
  output logic             pull,
  output logic             done
);
  logic       busy;
  logic [9:0] frame;
  logic [3:0] left;
  logic       tick;

  owm_bit_timer #(.W(DIV_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .load    (div - DIV_W'(1)),
    .period  (div),
    .run     (busy),
    .tick    (tick)
  );

  assign pull = busy && !frame[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      frame <= '1;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        frame <= {1'b1, pattern, 1'b0};
        left  <= 4'd10;
      end else if (busy && tick) begin
        frame <= {1'b1, frame[9:1]};
        left  <= left - 4'd1;
        if (left == 4'd1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/owm_rx.sv
module owm_rx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [DIV_W-1:0] div,
  input  logic             line,
  output logic [7:0]       data,
  output logic             stop_ok,
  output logic             done
);
  typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_SAMP} rx_st_e;

  rx_st_e     st;
  logic [3:0] idx;
  logic [7:0] sh;
  logic       tick;
  logic       restart;

  assign restart = (st == RX_HUNT) && !line;

  owm_bit_timer #(.W(DIV_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .load    ((div >> 1) - DIV_W'(1)),
    .period  (div),
    .run     (st == RX_SAMP),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      idx     <= '0;
      sh      <= '0;
      data    <= '0;
      stop_ok <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        st <= RX_HUNT;
      end else begin
        case (st)
          RX_HUNT: begin
            if (!line) begin
              st  <= RX_SAMP;
              idx <= '0;
            end
          end
          RX_SAMP: begin
            if (tick) begin
              idx <= idx + 4'd1;
              if (idx == 4'd0) begin
                if (line) st <= RX_HUNT;  // glitch, not a start bit
              end else if (idx <= 4'd8) begin
                sh <= {line, sh[7:1]};
              end else begin
                stop_ok <= line;
                data    <= sh;
                done    <= 1'b1;
                st      <= RX_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/owm_uart_master.sv
module owm_uart_master
  import owm_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int RST_BAUD   = 9600,
  parameter int SLOT_BAUD  = 115200,
  parameter int RST_LOW_NS = 520_000,
  parameter int W0_LOW_NS  = 69_600,
  parameter int W1_LOW_NS  = 8_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_code,
  output logic       res_valid,
  output logic       res_bit,
  output logic       res_short,
  output logic       ow_pull,
  input  logic       ow_sense
);
  localparam int DIV_RST  = owm_div(CLK_HZ, RST_BAUD);
  localparam int DIV_SLOT = owm_div(CLK_HZ, SLOT_BAUD);
  localparam int DIV_MAX  = (DIV_RST > DIV_SLOT) ? DIV_RST : DIV_SLOT;
  localparam int DIV_W    = $clog2(DIV_MAX + 1);

  localparam logic [7:0] RST_PAT = owm_pattern(owm_low_bits(RST_LOW_NS, CLK_HZ, DIV_RST));
  localparam logic [7:0] W0_PAT  = owm_pattern(owm_low_bits(W0_LOW_NS, CLK_HZ, DIV_SLOT));
  localparam logic [7:0] W1_PAT  = owm_pattern(owm_low_bits(W1_LOW_NS, CLK_HZ, DIV_SLOT));

  localparam logic [DIV_W-1:0] DIV_RST_V  = DIV_W'(DIV_RST);
  localparam logic [DIV_W-1:0] DIV_SLOT_V = DIV_W'(DIV_SLOT);

  typedef enum logic {M_IDLE, M_RUN} m_st_e;

  m_st_e            st;
  owm_cmd_e         code_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       pat_q;
  logic             slot_go;
  logic             tx_fin, rx_fin;
  logic             tx_done, rx_done;
  logic [7:0]       echo;
  logic             echo_stop;
  logic [1:0]       sense_q;
  logic             accept;
  logic             finish;
  logic             decode;

  assign cmd_ready = (st == M_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign finish    = (st == M_RUN) && (tx_fin || tx_done) && (rx_fin || rx_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= 2'b11;
    else        sense_q <= {sense_q[0], ow_sense};
  end

  owm_tx #(.DIV_W(DIV_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (slot_go),
    .div     (div_q),
    .pattern (pat_q),
    .pull    (ow_pull),
    .done    (tx_done)
  );

  owm_rx #(.DIV_W(DIV_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (slot_go),
    .div     (div_q),
    .line    (sense_q[1]),
    .data    (echo),
    .stop_ok (echo_stop),
    .done    (rx_done)
  );

  always_comb begin
    case (code_q)
      OWM_RESET: decode = (echo != RST_PAT);
      OWM_WR0:   decode = (echo == W0_PAT);
      OWM_WR1:   decode = (echo == W1_PAT);
      default:   decode = (echo == 8'hFF);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= M_IDLE;
      code_q    <= OWM_RESET;
      div_q     <= DIV_RST_V;
      pat_q     <= RST_PAT;
      slot_go   <= 1'b0;
      tx_fin    <= 1'b0;
      rx_fin    <= 1'b0;
      res_valid <= 1'b0;
      res_bit   <= 1'b0;
      res_short <= 1'b0;
    end else begin
      slot_go   <= 1'b0;
      res_valid <= 1'b0;
      if (accept) begin
        st      <= M_RUN;
        code_q  <= owm_cmd_e'(cmd_code);
        slot_go <= 1'b1;
        tx_fin  <= 1'b0;
        rx_fin  <= 1'b0;
        case (owm_cmd_e'(cmd_code))
          OWM_RESET: begin div_q <= DIV_RST_V;  pat_q <= RST_PAT; end
          OWM_WR0:   begin div_q <= DIV_SLOT_V; pat_q <= W0_PAT;  end
          default:   begin div_q <= DIV_SLOT_V; pat_q <= W1_PAT;  end
        endcase
      end else if (st == M_RUN) begin
        if (tx_done) tx_fin <= 1'b1;
        if (rx_done) rx_fin <= 1'b1;
        if (finish) begin
          st        <= M_IDLE;
          res_valid <= 1'b1;
          res_bit   <= decode;
          res_short <= !echo_stop;
        end
      end
    end
  end
endmodule

// File: rtl/owm_uart_master_chk.sv
module owm_uart_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic res_valid,
  input logic ow_pull
);
  // R1
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R1
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cmd_ready);

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !ow_pull);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind owm_uart_master owm_uart_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .res_valid (res_valid),
  .ow_pull   (ow_pull)
);

// File: tb/sim_owm_uart_master.sv
`timescale 1ns/1ps
module sim_owm_uart_master;
  localparam longint CLK_HZ = 1_200_000;
  localparam longint RB = 9600, SB = 115200;
  localparam longint RST_NS = 520_000, W0_NS = 69_600, W1_NS = 8_000;
  localparam int DR = int'((CLK_HZ + RB / 2) / RB);
  localparam int DS = int'((CLK_HZ + SB / 2) / SB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic cmd_ready, res_valid, res_bit, res_short, ow_pull, ow_sense;
  logic dev_pull = 1'b0, force_low = 1'b0;

  int checks = 0, fails = 0;
  int dev_mode = 0;
  int slot_div = DR, slot_low = 1;
  int tcnt = 0, run = 0, last_run = 0, rises = 0;
  int idle_pull_bad = 0, pulse_bad = 0;
  logic prev_pull = 1'b0, prev_rv = 1'b0, dev_active = 1'b0;

  always #5 clk = ~clk;

  assign ow_sense = !(ow_pull || dev_pull || force_low);

  owm_uart_master #(
    .CLK_HZ(int'(CLK_HZ)), .RST_BAUD(int'(RB)), .SLOT_BAUD(int'(SB)),
    .RST_LOW_NS(int'(RST_NS)), .W0_LOW_NS(int'(W0_NS)), .W1_LOW_NS(int'(W1_NS))
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .res_valid(res_valid), .res_bit(res_bit),
    .res_short(res_short), .ow_pull(ow_pull), .ow_sense(ow_sense)
  );

  function automatic int lbits(longint ns, longint div);
    longint den, n;
    den = div * 64'sd1000000000;
    n = (ns * CLK_HZ + den / 2) / den;
    if (n < 1) n = 1;
    if (n > 9) n = 9;
    return int'(n);
  endfunction

  function automatic logic [7:0] pat_of(int n);
    return 8'hFF << (n - 1);
  endfunction

  // device pulls low over this window, cycles counted from first pull cycle
  function automatic bit dev_win(int mode, int t, int div, int low);
    if (mode == 1) return t < 3 * DS;
    if (mode == 2) return (t >= low * div + DR / 4) && (t < low * div + DR / 4 + DR);
    return 1'b0;
  endfunction

  function automatic bit wire_low(int t, int mode, bit sh, int div, int low);
    return (t < low * div) || sh || dev_win(mode, t, div, low);
  endfunction

  // bus model and monitors, all on the falling edge
  always @(negedge clk) begin
    if (ow_pull && !prev_pull) begin
      tcnt = 0;
      dev_active = 1'b1;
      rises++;
    end else if (dev_active) begin
      tcnt++;
      if (tcnt > 12 * DR) dev_active = 1'b0;
    end
    dev_pull = dev_active && dev_win(dev_mode, tcnt, slot_div, slot_low);
    if (ow_pull) run++;
    else if (prev_pull) begin last_run = run; run = 0; end
    if (rst_n && cmd_ready && ow_pull) idle_pull_bad++;
    if (rst_n && res_valid && prev_rv) pulse_bad++;
    prev_pull = ow_pull;
    prev_rv = res_valid;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_result(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20 * DR; i++) begin
      @(negedge clk);
      if (res_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic run_slot(int code, int mode, bit sh);
    bit got;
    logic [7:0] e;
    bit stop_ok, exp_bit;
    int low, div;
    string tb, tl;
    div = (code == 0) ? DR : DS;
    low = (code == 0) ? lbits(RST_NS, DR) : (code == 1) ? lbits(W0_NS, DS) : lbits(W1_NS, DS);
    slot_div = div; slot_low = low;
    dev_mode = mode; force_low = sh;
    for (int i = 0; i < 8; i++) e[i] = !wire_low((i + 1) * div + div / 2, mode, sh, div, low);
    stop_ok = !wire_low(9 * div + div / 2, mode, sh, div, low);
    case (code)
      0: exp_bit = (e != pat_of(low));
      1, 2: exp_bit = (e == pat_of(low));
      default: exp_bit = (e == 8'hFF);
    endcase
    tb = (code == 0) ? "R6" : (code == 3) ? "R7" : "R8";
    tl = (code == 0) ? "R2 R5" : (code == 1) ? "R3 R5" : "R4 R5";
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'(code);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1 busy after accept", int'(cmd_ready), 0);
    wait_result(got);
    chk(got, "R1 result arrives", int'(got), 1);
    chk(res_bit == exp_bit, tb, int'(res_bit), int'(exp_bit));
    chk(res_short == !stop_ok, "R9 short flag", int'(res_short), int'(!stop_ok));
    chk(last_run == low * div, tl, last_run, low * div);
    force_low = 1'b0; dev_mode = 0;
    repeat (3 * DS) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    int r0;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready out of reset", int'(cmd_ready), 1);
    chk(ow_pull == 1'b0, "R10 released in reset", int'(ow_pull), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && res_valid == 1'b0, "R1 idle after reset", int'(res_valid), 0);
    chk(ow_pull == 1'b0, "R10 released when idle", int'(ow_pull), 0);

    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 3; m++)
        for (int s = 0; s < 2; s++)
          run_slot(c, m, s[0]);

    // R1: requests during a running slot are dropped
    r0 = rises;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'd3;
    @(negedge clk);
    cmd_code = 2'd0;
    repeat (5) @(negedge clk);
    cmd_valid = 1'b0;
    wait_result(got);
    chk(got && res_bit == 1'b1, "R1 busy request ignored, read result", int'(res_bit), 1);
    repeat (4 * DR) @(negedge clk);
    chk(rises - r0 == 1, "R1 one slot only", rises - r0, 1);
    chk(cmd_ready == 1'b1 && ow_pull == 1'b0, "R1 idle again", int'(cmd_ready), 1);

    chk(idle_pull_bad == 0, "R10 no pull while idle", idle_pull_bad, 0);
    chk(pulse_bad == 0, "R10 single-cycle result", pulse_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule